// File: doc/BRIEF.md
# Dual-IF Separation by Averaging

This block lets two cavity probe signals share one ADC. Upstream, the two signals are mixed down to different intermediate frequencies, one at 8 MHz and one at 12 MHz. They are then added together and digitised at 48 MHz. At that rate one 12 MHz cycle takes exactly 4 samples and one 8 MHz cycle takes exactly 6.

A boxcar sum taken over exactly one period of an IF cancels that IF and passes the other one. The block therefore keeps two running sums over the same input stream:

- A 4-sample window removes the 12 MHz component and leaves the 8 MHz signal.
- A 6-sample window removes the 8 MHz component and leaves the 12 MHz signal.

This works because the cavity envelopes, which have a high Q, barely move over a few samples. Summing several oversampled values also gains back some of the resolution lost by putting two signals through one converter. Each sum is kept at full precision and updated in a single step: the newest sample is added and the sample leaving the window is subtracted. The departing sample comes from a short shift-register delay line.

Top module: `dual_if_splitter`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and in the first cycle after it, both sums read zero and both valid strobes are low.
- R2: When `if1_vld` is high, `if1_sum` equals the exact signed sum of the last 4 accepted samples, with 18 bits and no rounding or truncation.
- R3: When `if2_vld` is high, `if2_sum` equals the exact signed sum of the last 6 accepted samples, with 19 bits and no rounding or truncation.
- R4: A sample is accepted on a rising clock edge where `smp_vld` is high. Both sums reflect that sample, and any valid strobe it raises is high, from that same edge onward, so there is one register of latency.
- R5: After reset, `if1_vld` stays low until the 4th accepted sample. From then on it pulses high for exactly one cycle for each accepted sample.
- R6: After reset, `if2_vld` stays low until the 6th accepted sample. From then on it pulses high for exactly one cycle for each accepted sample.
- R7: In a cycle where `smp_vld` is low, `smp_data` is ignored. Both sums hold their values and both strobes are low in the following cycle.
- R8: For a pure 12 MHz tone (4 samples per cycle, each rounded to the nearest integer), the magnitude of `if1_sum` is at most 2 once its window is full.
- R9: For a pure 8 MHz tone (6 samples per cycle, each rounded to the nearest integer), the magnitude of `if2_sum` is at most 3 once its window is full.
- R10: Full-scale inputs do not wrap:
  - Four samples of -32768 give `if1_sum` = -131072, and four of 32767 give 131068.
  - Six samples of -32768 give `if2_sum` = -196608, and six of 32767 give 196602.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Marks `smp_data` as a new sample |
| smp_data | input | 16 | Signed combined ADC sample |
| if1_sum | output | 18 | 4-sample running sum (8 MHz channel) |
| if1_vld | output | 1 | `if1_sum` holds a full window |
| if2_sum | output | 19 | 6-sample running sum (12 MHz channel) |
| if2_vld | output | 1 | `if2_sum` holds a full window |

## Verification
The checks assume that every accepted sample is a legal signed 16-bit value. They also assume that the strobe alone defines the window, so a gap in `smp_vld` simply stretches the window in time. Under those assumptions the sums can never leave the range of four or six full-scale samples, and a strobe can only follow an accepted sample.

The stimulus stays within these assumptions. It drives plain 16-bit values, including both extremes, and inserts idle cycles only through `smp_vld`. It resets before each tone, so that the null bounds are judged on windows that contain nothing but samples of that tone.

// File: rtl/dual_if_splitter.sv
module dual_if_splitter #(
  parameter int DW    = 16,
  parameter int TAPS1 = 4,
  parameter int TAPS2 = 6
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   smp_vld,
  input  logic signed [DW-1:0]                   smp_data,
  output logic signed [DW+$clog2(TAPS1)-1:0]     if1_sum,
  output logic                                   if1_vld,
  output logic signed [DW+$clog2(TAPS2)-1:0]     if2_sum,
  output logic                                   if2_vld
);
  localparam int W1  = DW + $clog2(TAPS1);
  localparam int W2  = DW + $clog2(TAPS2);
  localparam int CW1 = $clog2(TAPS1 + 1);
  localparam int CW2 = $clog2(TAPS2 + 1);

  logic [TAPS1-1:0][DW-1:0] line1;
  logic [TAPS2-1:0][DW-1:0] line2;
  logic [CW1-1:0]           fill1;
  logic [CW2-1:0]           fill2;

  wire signed [W1-1:0] new1 = {{(W1-DW){smp_data[DW-1]}}, smp_data};
  wire signed [W1-1:0] old1 = {{(W1-DW){line1[TAPS1-1][DW-1]}}, line1[TAPS1-1]};
  wire signed [W2-1:0] new2 = {{(W2-DW){smp_data[DW-1]}}, smp_data};
  wire signed [W2-1:0] old2 = {{(W2-DW){line2[TAPS2-1][DW-1]}}, line2[TAPS2-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line1   <= '0;
      fill1   <= '0;
      if1_sum <= '0;
      if1_vld <= 1'b0;
    end else if (smp_vld) begin
      line1   <= {line1[TAPS1-2:0], smp_data};
      if1_sum <= if1_sum + new1 - old1;
      if1_vld <= (fill1 >= CW1'(TAPS1 - 1));
      if (fill1 != CW1'(TAPS1)) fill1 <= fill1 + 1'b1;
    end else begin
      if1_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line2   <= '0;
      fill2   <= '0;
      if2_sum <= '0;
      if2_vld <= 1'b0;
    end else if (smp_vld) begin
      line2   <= {line2[TAPS2-2:0], smp_data};
      if2_sum <= if2_sum + new2 - old2;
      if2_vld <= (fill2 >= CW2'(TAPS2 - 1));
      if (fill2 != CW2'(TAPS2)) fill2 <= fill2 + 1'b1;
    end else begin
      if2_vld <= 1'b0;
    end
  end
endmodule

module dual_if_splitter_chk #(
  parameter int DW    = 16,
  parameter int TAPS1 = 4,
  parameter int TAPS2 = 6
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               smp_vld,
  input logic signed [DW+$clog2(TAPS1)-1:0] if1_sum,
  input logic                               if1_vld,
  input logic signed [DW+$clog2(TAPS2)-1:0] if2_sum,
  input logic                               if2_vld
);
  localparam int LIM1 = TAPS1 * ((1 << (DW - 1)) - 1);
  localparam int LIM2 = TAPS2 * ((1 << (DW - 1)) - 1);
  localparam int MIN1 = -TAPS1 * (1 << (DW - 1));
  localparam int MIN2 = -TAPS2 * (1 << (DW - 1));

  logic [4:0] seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= '0;
    else if (smp_vld && seen != 5'd31) seen <= seen + 1'b1;

  // R4
  strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if1_vld || if2_vld) |-> $past(smp_vld));

  // R5
  if1_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if1_vld |-> (int'(seen) >= TAPS1));

  // R5
  if1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && int'(seen) >= TAPS1 - 1) |=> if1_vld);

  // R6
  if2_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if2_vld |-> (int'(seen) >= TAPS2));

  // R6
  if2_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && int'(seen) >= TAPS2 - 1) |=> if2_vld);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> ($stable(if1_sum) && $stable(if2_sum) && !if1_vld && !if2_vld));

  // R10
  sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(if1_sum) <= LIM1) && (int'(if1_sum) >= MIN1) &&
    (int'(if2_sum) <= LIM2) && (int'(if2_sum) >= MIN2));
endmodule

bind dual_if_splitter dual_if_splitter_chk #(.DW(DW), .TAPS1(TAPS1), .TAPS2(TAPS2)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
  .if1_sum(if1_sum), .if1_vld(if1_vld), .if2_sum(if2_sum), .if2_vld(if2_vld)
);

// File: tb/sim_dual_if_splitter.sv
module sim_dual_if_splitter;
  localparam int PERIOD = 10;
  localparam int N = 10;
  localparam int STIM [N] = '{10, 20, 30, 40, 50, 60, -100, 1000, -32768, 32767};
  localparam int EXP1 [N] = '{10, 30, 60, 100, 140, 180, 50, 1010, -31808, 899};
  localparam int EXP2 [N] = '{10, 30, 60, 100, 150, 210, 100, 1080, -31718, 1009};
  localparam bit EV1 [N] = '{0, 0, 0, 1, 1, 1, 1, 1, 1, 1};
  localparam bit EV2 [N] = '{0, 0, 0, 0, 0, 1, 1, 1, 1, 1};

  logic clk = 0;
  logic rst_n = 0;
  logic smp_vld = 0;
  logic signed [15:0] smp_data = '0;
  logic signed [17:0] if1_sum;
  logic if1_vld;
  logic signed [18:0] if2_sum;
  logic if2_vld;
  int checks = 0;
  int errors = 0;
  int hist [6];

  always #(PERIOD/2) clk = ~clk;

  dual_if_splitter u0 (.clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .if1_sum(if1_sum), .if1_vld(if1_vld), .if2_sum(if2_sum), .if2_vld(if2_vld));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input int d);
    smp_vld = v;
    smp_data = 16'(d);
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0;
    smp_vld = 0;
    repeat (2) @(posedge clk);
    #1;
    // R1
    chk(if1_sum == 0 && if2_sum == 0, "R1 sums", int'(if1_sum) + int'(if2_sum), 0);
    chk(!if1_vld && !if2_vld, "R1 strobes", int'(if1_vld) + int'(if2_vld), 0);
    rst_n = 1;
    for (int k = 0; k < 6; k++) hist[k] = 0;
  endtask

  function automatic int tone(input int n, input real per, input real ph);
    real x;
    x = 20000.0 * $sin(2.0 * 3.14159265358979 * n / per + ph);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int abs_i(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic push_hist(input int v);
    for (int k = 5; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = v;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD/4);
    do_reset();
    // R1 first cycle out of reset, no sample yet
    drive(0, 0);
    chk(!if1_vld && !if2_vld && if1_sum == 0, "R1 after release", int'(if1_sum), 0);

    for (int i = 0; i < N; i++) begin
      drive(1, STIM[i]);
      // R4 R5 R6
      chk(if1_vld == EV1[i], "R5 if1_vld", int'(if1_vld), int'(EV1[i]));
      chk(if2_vld == EV2[i], "R6 if2_vld", int'(if2_vld), int'(EV2[i]));
      // R2
      if (EV1[i]) chk(int'(if1_sum) == EXP1[i], "R2 if1_sum", int'(if1_sum), EXP1[i]);
      // R3
      if (EV2[i]) chk(int'(if2_sum) == EXP2[i], "R3 if2_sum", int'(if2_sum), EXP2[i]);
      if (i % 2 == 1) begin
        drive(0, -12345);
        // R7
        chk(int'(if1_sum) == EXP1[i], "R7 if1 hold", int'(if1_sum), EXP1[i]);
        chk(int'(if2_sum) == EXP2[i], "R7 if2 hold", int'(if2_sum), EXP2[i]);
        chk(!if1_vld && !if2_vld, "R7 strobes low", int'(if1_vld) + int'(if2_vld), 0);
      end
    end

    do_reset();
    for (int n = 0; n < 24; n++) begin
      push_hist(tone(n, 4.0, 0.3));
      drive(1, hist[0]);
      // R8
      if (n >= 3) chk(abs_i(int'(if1_sum)) <= 2, "R8 12MHz null", int'(if1_sum), 0);
      // R3
      if (n >= 5) chk(int'(if2_sum) == hist[0]+hist[1]+hist[2]+hist[3]+hist[4]+hist[5],
                      "R3 12MHz pass", int'(if2_sum), hist[0]+hist[1]+hist[2]+hist[3]+hist[4]+hist[5]);
    end

    do_reset();
    for (int n = 0; n < 24; n++) begin
      push_hist(tone(n, 6.0, 1.1));
      drive(1, hist[0]);
      // R9
      if (n >= 5) chk(abs_i(int'(if2_sum)) <= 3, "R9 8MHz null", int'(if2_sum), 0);
      // R2
      if (n >= 3) chk(int'(if1_sum) == hist[0]+hist[1]+hist[2]+hist[3],
                      "R2 8MHz pass", int'(if1_sum), hist[0]+hist[1]+hist[2]+hist[3]);
    end

    do_reset();
    for (int n = 0; n < 6; n++) drive(1, -32768);
    // R10
    chk(int'(if1_sum) == -131072, "R10 if1 min", int'(if1_sum), -131072);
    chk(int'(if2_sum) == -196608, "R10 if2 min", int'(if2_sum), -196608);
    for (int n = 0; n < 6; n++) drive(1, 32767);
    chk(int'(if1_sum) == 131068, "R10 if1 max", int'(if1_sum), 131068);
    chk(int'(if2_sum) == 196602, "R10 if2 max", int'(if2_sum), 196602);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule